// File: doc/BRIEF.md
# Tachometer Period Speed Discriminator with Lock Detect

This block judges motor speed by counting reference ticks between consecutive tachometer (FG) edges. The reference tick enable runs at 512 times the commanded speed clock, so a motor at the commanded speed produces exactly 512 ticks per tachometer period. At every tachometer edge that closes a complete period, the block publishes one result: a direction (speed up or slow down) and a signed, clamped size of the error. A downstream integrator turns these results into a drive command.

The same result also updates a lock decision. When the measured count lies within ±6.25% of nominal (±32 ticks), the active-low lock output is driven low and the drive-mode output asks for soft-switching commutation. Outside the window the block asks for plain 120-degree commutation. A freshly reset block stays unlocked until it has measured two complete periods.

Top module: `sd_discriminator`

## Requirements
- R1: While reset is asserted and until the first result: err_valid=0, err_up=0, err_dn=0, err_mag=0, lock_n=1, soft_mode=0.
- R2: The period count is the number of cycles with ref_tick=1 after the previous fg_edge cycle, up to and including the cycle of the closing fg_edge; cycles with ref_tick=0 are not counted.
- R3: err_valid is a one-cycle pulse in the cycle after each fg_edge that closes a complete period. The first fg_edge after reset only starts a measurement and gives no pulse.
- R4: With the pulse, err_up=1 when the count is above 512 (motor slow), err_dn=1 when it is below 512 (motor fast), and both are 0 at exactly 512 and outside the pulse.
- R5: err_mag is the two's-complement 9-bit value of (count − 512) clamped to the range −255..+255, held between results.
- R6: The period counter saturates at 1023. A saturated period reports err_up=1, err_mag=+255, and is never in lock.
- R7: Each result sets lock_n=0 when the count is within 480..544 inclusive and lock_n=1 otherwise. lock_n keeps its value between results.
- R8: After reset, lock_n stays 1 for the first complete period, even when it is in the window. Lock can be taken from the second complete period on.
- R9: soft_mode is 1 exactly when lock_n is 0, so 120-degree drive is requested whenever the block is out of lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference tick enable (512 × commanded speed) |
| fg_edge | input | 1 | One-cycle pulse per tachometer period edge |
| err_valid | output | 1 | One-cycle pulse per complete period |
| err_up | output | 1 | Accelerate request, with err_valid |
| err_dn | output | 1 | Decelerate request, with err_valid |
| err_mag | output | 9 | Signed clamped count error, held |
| lock_n | output | 1 | Low while speed is in the lock window |
| soft_mode | output | 1 | 1 = soft-switching drive, 0 = 120-degree drive |

## Verification
The bench sweeps every period length from 470 to 556 ticks. This crosses both lock-window edges (479/480 and 544/545) and the zero-error point 512. A window coded with strict comparisons, or shifted by one tick, would flip lock_n on those exact counts. An off-by-one in the count, such as missing the closing edge cycle, would shift every reported magnitude by one. Long periods drive the counter into saturation: a counter that wrapped would report a fast motor with a small error. Periods with the tick enable at half rate show whether gated cycles are wrongly counted. Resets in the middle of a run check that lock is not taken on the very first complete period.

// File: rtl/sd_pkg.sv
package sd_pkg;
    localparam int SD_CNT_W   = 10;
    localparam int SD_NOMINAL = 512;
    localparam int SD_WINDOW  = 32;
    localparam int SD_MAG_W   = 9;
endpackage

// File: rtl/sd_tick_counter.sv
module sd_tick_counter
    import sd_pkg::*;
#(
    parameter int CNT_W = SD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             fg_edge,
    output logic [CNT_W-1:0] meas,
    output logic             meas_valid,
    output logic             meas_mature
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             started;
        logic [1:0]       seen;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        meas = (ref_tick && st_q.cnt != CNT_MAX) ? st_q.cnt + 1'b1 : st_q.cnt;
        meas_valid  = fg_edge && st_q.started;
        meas_mature = (st_q.seen != 2'd0);
        if (fg_edge) begin
            st_d.cnt     = '0;
            st_d.started = 1'b1;
            if (st_q.started && st_q.seen != 2'd2)
                st_d.seen = st_q.seen + 2'd1;
        end else begin
            st_d.cnt = meas;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: once at the limit the count stays there until an edge restarts it
    a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !fg_edge) |=> (st_q.cnt == CNT_MAX));

    // R2: an edge always restarts the count from zero
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        fg_edge |=> (st_q.cnt == '0));
endmodule

// File: rtl/sd_error_calc.sv
module sd_error_calc
    import sd_pkg::*;
#(
    parameter int CNT_W   = SD_CNT_W,
    parameter int NOMINAL = SD_NOMINAL,
    parameter int WINDOW  = SD_WINDOW,
    parameter int MAG_W   = SD_MAG_W
) (
    input  logic [CNT_W-1:0]        meas,
    output logic                    in_window,
    output logic                    slow,
    output logic                    fast,
    output logic signed [MAG_W-1:0] mag
);
    localparam int DW = CNT_W + 2;
    localparam int MAG_LIM = (1 << (MAG_W - 1)) - 1;
    localparam logic signed [DW-1:0] NOM_S  = DW'(NOMINAL);
    localparam logic signed [DW-1:0] LIM_P  = DW'(MAG_LIM);
    localparam logic signed [DW-1:0] LIM_N  = -LIM_P;
    localparam logic signed [DW-1:0] WIN_P  = DW'(WINDOW);
    localparam logic signed [DW-1:0] WIN_N  = -WIN_P;

    logic signed [DW-1:0] diff;

    always_comb begin
        diff      = $signed({2'b00, meas}) - NOM_S;
        slow      = diff > 0;
        fast      = diff < 0;
        in_window = (diff >= WIN_N) && (diff <= WIN_P);
        if (diff > LIM_P)      mag = LIM_P[MAG_W-1:0];
        else if (diff < LIM_N) mag = LIM_N[MAG_W-1:0];
        else                   mag = diff[MAG_W-1:0];
    end
endmodule

// File: rtl/sd_discriminator.sv
module sd_discriminator
    import sd_pkg::*;
#(
    parameter int CNT_W   = SD_CNT_W,
    parameter int NOMINAL = SD_NOMINAL,
    parameter int WINDOW  = SD_WINDOW,
    parameter int MAG_W   = SD_MAG_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_tick,
    input  logic                    fg_edge,
    output logic                    err_valid,
    output logic                    err_up,
    output logic                    err_dn,
    output logic signed [MAG_W-1:0] err_mag,
    output logic                    lock_n,
    output logic                    soft_mode
);
    localparam int MAG_LIM = (1 << (MAG_W - 1)) - 1;

    typedef struct packed {
        logic             valid;
        logic             up;
        logic             dn;
        logic [MAG_W-1:0] mag;
        logic             locked;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [CNT_W-1:0]        meas;
    logic                    meas_valid, meas_mature;
    logic                    in_window, slow, fast;
    logic signed [MAG_W-1:0] cmag;

    sd_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fg_edge(fg_edge),
        .meas(meas), .meas_valid(meas_valid), .meas_mature(meas_mature)
    );

    sd_error_calc #(.CNT_W(CNT_W), .NOMINAL(NOMINAL), .WINDOW(WINDOW), .MAG_W(MAG_W)) u_calc (
        .meas(meas), .in_window(in_window), .slow(slow), .fast(fast), .mag(cmag)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = meas_valid;
        st_d.up    = meas_valid && slow;
        st_d.dn    = meas_valid && fast;
        if (meas_valid) begin
            st_d.mag    = cmag;
            st_d.locked = in_window && meas_mature;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_valid = st_q.valid;
    assign err_up    = st_q.up;
    assign err_dn    = st_q.dn;
    assign err_mag   = $signed(st_q.mag);
    assign lock_n    = !st_q.locked;
    assign soft_mode = st_q.locked;

    // R3: a result only ever follows an edge
    a_r3_valid_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(fg_edge));

    // R4: direction flags are exclusive and only present with a result
    a_r4_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_up && err_dn));
    a_r4_dir_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (err_up || err_dn) |-> err_valid);

    // R5: magnitude stays inside the clamp range
    a_r5_mag_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(err_mag) <= MAG_LIM) && (int'(err_mag) >= -MAG_LIM));

    // R7: lock and magnitude change only together with a result
    a_r7_lock_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_n) |-> err_valid);
    a_r5_mag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_mag) |-> err_valid);
endmodule

// File: tb/sd_discriminator_test.sv
module sd_discriminator_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic fg_edge = 1'b0;
    logic err_valid, err_up, err_dn, lock_n, soft_mode;
    logic signed [8:0] err_mag;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model
    bit started = 0;
    int complete = 0;
    bit exp_locked = 0;
    bit pending = 0;
    bit pend_noval = 0;
    int exp_mag = 0;
    bit exp_up = 0, exp_dn = 0;
    int exp_meas = 0;
    bit half_rate = 0;

    always #4 clk = ~clk;

    sd_discriminator uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fg_edge(fg_edge),
        .err_valid(err_valid), .err_up(err_up), .err_dn(err_dn),
        .err_mag(err_mag), .lock_n(lock_n), .soft_mode(soft_mode)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (count %0d)", req, what, act, exp, exp_meas);
        end
    endtask

    task automatic check_pending();
        if (pending) begin
            chk("R3", int'(err_valid), 1, "valid pulse");
            chk("R4", int'(err_up), int'(exp_up), "err_up");
            chk("R4", int'(err_dn), int'(exp_dn), "err_dn");
            chk("R5", int'(err_mag), exp_mag, "err_mag");
            chk("R7", int'(lock_n), int'(!exp_locked), "lock_n");
            chk("R9", int'(soft_mode), int'(exp_locked), "soft_mode");
            if (exp_meas == 1023) chk("R6", int'(err_mag), 255, "saturated magnitude");
        end else if (pend_noval) begin
            chk("R3", int'(err_valid), 0, "no pulse on first edge");
            chk("R8", int'(lock_n), 1, "unlocked at start");
        end
        pending = 0;
        pend_noval = 0;
    endtask

    // one tachometer period of n cycles; the closing edge is in the last cycle
    task automatic period(input int n);
        int ticks;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i == 1) check_pending();
            if (i == 2) chk("R3", int'(err_valid), 0, "pulse is one cycle");
            if (i == 2) chk("R4", int'(err_up || err_dn), 0, "no direction outside pulse");
            ref_tick = half_rate ? (i % 2 == 0) : 1'b1;
            fg_edge  = (i == n);
        end
        ticks = half_rate ? n / 2 : n;
        if (started) begin
            exp_meas = (ticks > 1023) ? 1023 : ticks;
            exp_up = exp_meas > 512;
            exp_dn = exp_meas < 512;
            exp_mag = exp_meas - 512;
            if (exp_mag > 255) exp_mag = 255;
            if (exp_mag < -255) exp_mag = -255;
            complete++;
            exp_locked = (exp_meas >= 480) && (exp_meas <= 544) && (complete >= 2);
            pending = 1;
        end else begin
            started = 1;
            pend_noval = 1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fg_edge = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", int'(err_valid), 0, "reset valid");
        chk("R1", int'(err_up || err_dn), 0, "reset direction");
        chk("R1", int'(err_mag), 0, "reset magnitude");
        chk("R1", int'(lock_n), 1, "reset lock_n");
        chk("R1", int'(soft_mode), 0, "reset soft_mode");
        rst_n = 1'b1;
        started = 0; complete = 0; exp_locked = 0; pending = 0; pend_noval = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R8: first complete period is on target but must not lock
        period(600);
        period(512);
        period(512);            // R8: second complete period takes lock
        // R7, R4, R5: sweep across both window edges and zero
        for (int n = 470; n <= 556; n++) period(n);
        // R5: clamp on both sides, R6: saturation
        period(100);
        period(900);
        period(1100);           // R6: saturates at 1023
        period(1500);
        period(512);
        period(530);
        // R2: tick enable at half rate, count halves
        half_rate = 1;
        period(1024);           // count 512
        period(960);            // count 480, R7 lower edge
        period(958);            // count 479
        period(1090);           // count 545
        period(1088);           // count 544
        half_rate = 0;
        // R8 again after a mid-run reset while locked
        do_reset();
        period(300);
        period(500);
        period(520);
        period(540);
        @(negedge clk);
        check_pending();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule